// File: doc/BRIEF.md
# Single-Fault Memory Emulator

This block wraps a small bit-wide storage array and makes it misbehave in one controlled way, so that a memory test sequencer can be shown to catch the fault. A sequencer issues single-port read and write requests. The block either serves each request faithfully, or bends the stored or returned bit according to the fault model chosen on its configuration inputs.

The configuration chooses the fault kind, the victim cell, the aggressor cell and three polarity bits. The fault kinds are a cell stuck at a value, a cell that cannot make one of its two transitions, a coupling that forces the victim to a value, and a coupling that inverts the victim. A coupling fires only when a write actually flips the aggressor into the trigger value. The configuration is expected to be changed only while reset is held.

Top module: `mfe_fault_emu`

## Requirements
- R1: While `rst_n` is low every cell is cleared to 0 and `rsp_rdata` is 0. After reset, a read of any cell that has not been written returns 0, except for the stuck-at victim covered by R4.
- R2: A read request (`req_en`=1, `req_we`=0) puts its data on `rsp_rdata` one clock edge later. `rsp_rdata` keeps that value until the next read request.
- R3: With `cfg_kind`=0 (no fault), every read returns the last value written to that address.
- R4: With `cfg_kind`=1 (stuck-at), a read of the victim always returns `cfg_pol`, whatever has been written to it.
- R5: With `cfg_kind`=2 (transition) and `cfg_pol`=0, a victim holding 0 ignores a write of 1. Once the victim holds 0, it reads 0 from then on.
- R6: With `cfg_kind`=2 and `cfg_pol`=1, a victim holding 1 ignores a write of 0. Writes that move it from 0 to 1 do take effect.
- R7: With `cfg_kind`=3 (forcing coupling), a write that changes the aggressor from `!cfg_trig` to `cfg_trig` sets the victim to `cfg_force` at the same edge. A read of the victim in the next cycle returns `cfg_force`.
- R8: With `cfg_kind`=4 (inverting coupling), the same kind of aggressor write inverts the victim at that edge.
- R9: A coupling does not fire on an aggressor write that leaves its value unchanged, nor on a transition away from `cfg_trig`.
- R10: In every fault kind, a cell other than the victim reads back its last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_kind | input | 3 | Fault kind: 0 none, 1 stuck-at, 2 transition, 3 forcing coupling, 4 inverting coupling |
| cfg_victim | input | AW | Victim cell address |
| cfg_aggr | input | AW | Aggressor cell address (must differ from the victim for kinds 3 and 4) |
| cfg_pol | input | 1 | Stuck value (kind 1), or the value the victim cannot leave (kind 2) |
| cfg_trig | input | 1 | Aggressor value whose arrival fires a coupling |
| cfg_force | input | 1 | Value written into the victim by a forcing coupling |
| req_en | input | 1 | Request valid |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Cell address |
| req_wdata | input | 1 | Write data |
| rsp_rdata | output | 1 | Registered read data |

## Verification
Every read result appears exactly one rising edge after the request, so the bench drives a request at a falling edge and compares `rsp_rdata` at the next falling edge. The side effect of a write, including a coupling update of the victim, lands at the same edge as the write. The bench therefore checks it through a read issued in the very next cycle, and that read's data is sampled one further falling edge on. Reference values come from a bench model of the fault rules. It is updated at the moment each request is issued, so it always stands one edge ahead of the data it predicts.

// File: rtl/mfe_pkg.sv
package mfe_pkg;
   typedef enum logic [2:0] {
      FLT_NONE  = 3'd0,
      FLT_STUCK = 3'd1,
      FLT_TRANS = 3'd2,
      FLT_IDEM  = 3'd3,
      FLT_INV   = 3'd4
   } flt_kind_e;
endpackage

// File: rtl/mfe_cell_array.sv
module mfe_cell_array #(
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] wr_mask,
   input  logic [DEPTH-1:0] wr_val,
   output logic [DEPTH-1:0] cell_q
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (!rst_n)          cell_q[i] <= 1'b0;
         else if (wr_mask[i]) cell_q[i] <= wr_val[i];
      end
   end
endmodule

// File: rtl/mfe_fault_ctrl.sv
module mfe_fault_ctrl
   import mfe_pkg::*;
#(
   parameter int DEPTH        = 16,
   parameter bit HAS_COUPLING = 1'b1,
   localparam int AW          = $clog2(DEPTH)
) (
   input  flt_kind_e        kind,
   input  logic [AW-1:0]    victim,
   input  logic [AW-1:0]    aggr,
   input  logic             pol,
   input  logic             trig,
   input  logic             force_val,
   input  logic             req_en,
   input  logic             req_we,
   input  logic [AW-1:0]    req_addr,
   input  logic             req_wdata,
   input  logic [DEPTH-1:0] cell_q,
   output logic [DEPTH-1:0] wr_mask,
   output logic [DEPTH-1:0] wr_val
);
   logic do_wr, cur_bit, main_val, cpl_hit, cpl_val;

   assign do_wr   = req_en && req_we;
   assign cur_bit = cell_q[req_addr];

   // data that lands in the addressed cell
   always_comb begin
      main_val = req_wdata;
      if (req_addr == victim) begin
         case (kind)
            FLT_STUCK: main_val = pol;
            FLT_TRANS: main_val = (cur_bit == pol) ? pol : req_wdata;
            default:   main_val = req_wdata;
         endcase
      end
   end

   if (HAS_COUPLING) begin : g_cpl
      logic cpl_kind;
      assign cpl_kind = (kind == FLT_IDEM) || (kind == FLT_INV);
      assign cpl_hit  = do_wr && cpl_kind && (req_addr == aggr) &&
                        (cur_bit != req_wdata) && (req_wdata == trig);
      assign cpl_val  = (kind == FLT_IDEM) ? force_val : !cell_q[victim];
   end else begin : g_nocpl
      assign cpl_hit = 1'b0;
      assign cpl_val = 1'b0;
   end

   always_comb begin
      wr_mask = '0;
      wr_val  = cell_q;
      if (do_wr) begin
         wr_mask[req_addr] = 1'b1;
         wr_val[req_addr]  = main_val;
      end
      if (cpl_hit) begin
         wr_mask[victim] = 1'b1;
         wr_val[victim]  = cpl_val;
      end
   end
endmodule

// File: rtl/mfe_read_port.sv
module mfe_read_port
   import mfe_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  flt_kind_e        kind,
   input  logic [AW-1:0]    victim,
   input  logic             pol,
   input  logic             req_en,
   input  logic             req_we,
   input  logic [AW-1:0]    req_addr,
   input  logic [DEPTH-1:0] cell_q,
   output logic             rdata
);
   logic rd_bit;
   assign rd_bit = (kind == FLT_STUCK && req_addr == victim) ? pol : cell_q[req_addr];

   always_ff @(posedge clk) begin
      if (!rst_n)                rdata <= 1'b0;
      else if (req_en && !req_we) rdata <= rd_bit;
   end
endmodule

// File: rtl/mfe_fault_emu.sv
module mfe_fault_emu
   import mfe_pkg::*;
#(
   parameter int DEPTH        = 16,
   parameter bit HAS_COUPLING = 1'b1,
   localparam int AW          = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    cfg_kind,
   input  logic [AW-1:0] cfg_victim,
   input  logic [AW-1:0] cfg_aggr,
   input  logic          cfg_pol,
   input  logic          cfg_trig,
   input  logic          cfg_force,
   input  logic          req_en,
   input  logic          req_we,
   input  logic [AW-1:0] req_addr,
   input  logic          req_wdata,
   output logic          rsp_rdata
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("mfe_fault_emu: DEPTH must be a power of two of at least 2");
   end

   flt_kind_e        kind;
   logic [DEPTH-1:0] store_q, wr_mask, wr_val;

   assign kind = flt_kind_e'(cfg_kind);

   mfe_fault_ctrl #(.DEPTH(DEPTH), .HAS_COUPLING(HAS_COUPLING)) u_ctrl (
      .kind(kind), .victim(cfg_victim), .aggr(cfg_aggr), .pol(cfg_pol),
      .trig(cfg_trig), .force_val(cfg_force), .req_en(req_en), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .cell_q(store_q),
      .wr_mask(wr_mask), .wr_val(wr_val)
   );

   mfe_cell_array #(.DEPTH(DEPTH)) u_cells (
      .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask), .wr_val(wr_val), .cell_q(store_q)
   );

   mfe_read_port #(.DEPTH(DEPTH)) u_rd (
      .clk(clk), .rst_n(rst_n), .kind(kind), .victim(cfg_victim), .pol(cfg_pol),
      .req_en(req_en), .req_we(req_we), .req_addr(req_addr), .cell_q(store_q),
      .rdata(rsp_rdata)
   );
endmodule

// File: rtl/mfe_checker.sv
module mfe_checker #(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       cfg_kind,
   input logic [AW-1:0]    cfg_victim,
   input logic [AW-1:0]    cfg_aggr,
   input logic             cfg_pol,
   input logic             cfg_trig,
   input logic             cfg_force,
   input logic             req_en,
   input logic             req_we,
   input logic [AW-1:0]    req_addr,
   input logic             req_wdata,
   input logic             rsp_rdata,
   input logic [DEPTH-1:0] store_q
);
   logic wr_aggr, rd_req;
   assign wr_aggr = req_en && req_we && req_addr == cfg_aggr;
   assign rd_req  = req_en && !req_we;

   assert_stuck_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && cfg_kind == 3'd1 && req_addr == cfg_victim) |=> rsp_rdata == $past(cfg_pol));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(rsp_rdata));

   assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_en && req_we && cfg_kind == 3'd0) |=>
      (rd_req && cfg_kind == 3'd0 && req_addr == $past(req_addr)) |=>
      rsp_rdata == $past(req_wdata, 2));

   assert_trans_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_en && req_we && cfg_kind == 3'd2 && req_addr == cfg_victim &&
       store_q[cfg_victim] == cfg_pol) |=> store_q[cfg_victim] == $past(cfg_pol));

   assert_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_aggr && cfg_kind == 3'd3 && store_q[cfg_aggr] != req_wdata && req_wdata == cfg_trig)
      |=> store_q[cfg_victim] == $past(cfg_force));

   assert_invert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_aggr && cfg_kind == 3'd4 && store_q[cfg_aggr] != req_wdata && req_wdata == cfg_trig)
      |=> store_q[cfg_victim] != $past(store_q[cfg_victim]));

   assert_no_trigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_aggr && (cfg_kind == 3'd3 || cfg_kind == 3'd4) &&
       (store_q[cfg_aggr] == req_wdata || req_wdata != cfg_trig))
      |=> $stable(store_q[cfg_victim]));

   assert_distinct_cells_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_kind == 3'd3 || cfg_kind == 3'd4) |-> cfg_victim != cfg_aggr);
endmodule

bind mfe_fault_emu mfe_checker #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_kind(cfg_kind), .cfg_victim(cfg_victim),
   .cfg_aggr(cfg_aggr), .cfg_pol(cfg_pol), .cfg_trig(cfg_trig), .cfg_force(cfg_force),
   .req_en(req_en), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
   .rsp_rdata(rsp_rdata), .store_q(store_q)
);

// File: tb/mfe_fault_emu_test.sv
module mfe_fault_emu_test;
   localparam int DEPTH = 16;
   localparam int AW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    cfg_kind = '0;
   logic [AW-1:0] cfg_victim = '0, cfg_aggr = '0;
   logic          cfg_pol = 0, cfg_trig = 0, cfg_force = 0;
   logic          req_en = 0, req_we = 0, req_wdata = 0;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_rdata;

   int  n_chk = 0, n_fail = 0;
   bit  done = 0;
   logic model [DEPTH];

   always #10 clk = ~clk;

   mfe_fault_emu #(.DEPTH(DEPTH)) uut (.*);

   task automatic check(input logic act, input logic exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: rsp_rdata=%0b expected %0b", req, act, exp);
      end
   endtask

   task automatic do_reset();
      req_en = 0; rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      for (int i = 0; i < DEPTH; i++) model[i] = 1'b0;
   endtask

   // reference model of a write under the current configuration
   task automatic model_write(input logic [AW-1:0] a, input logic d);
      logic cur = model[a];
      if (a == cfg_victim && cfg_kind == 3'd1) model[a] = cfg_pol;
      else if (a == cfg_victim && cfg_kind == 3'd2 && cur == cfg_pol) model[a] = cfg_pol;
      else model[a] = d;
      if ((cfg_kind == 3'd3 || cfg_kind == 3'd4) && a == cfg_aggr && cur != d && d == cfg_trig)
         model[cfg_victim] = (cfg_kind == 3'd3) ? cfg_force : !model[cfg_victim];
   endtask

   function automatic logic model_read(input logic [AW-1:0] a);
      return (cfg_kind == 3'd1 && a == cfg_victim) ? cfg_pol : model[a];
   endfunction

   function automatic string tag_for(input logic [AW-1:0] a);
      if (a != cfg_victim) return "R10";
      case (cfg_kind)
         3'd0: return "R3";
         3'd1: return "R4";
         3'd2: return cfg_pol ? "R6" : "R5";
         3'd3: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic wr(input logic [AW-1:0] a, input logic d);
      req_en = 1; req_we = 1; req_addr = a; req_wdata = d;
      model_write(a, d);
      @(negedge clk);
      req_en = 0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input string req);
      logic exp = model_read(a);
      req_en = 1; req_we = 0; req_addr = a;
      @(negedge clk);
      req_en = 0;
      check(rsp_rdata, exp, req);
   endtask

   task automatic configure(input logic [2:0] k, input logic [AW-1:0] v, input logic [AW-1:0] g,
                            input logic p, input logic t, input logic f);
      rst_n = 0;
      cfg_kind = k; cfg_victim = v; cfg_aggr = g; cfg_pol = p; cfg_trig = t; cfg_force = f;
      do_reset();
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED_0042);
      do_reset();
      // R1: cleared after reset
      rd(4'd3, "R1");
      rd(4'd15, "R1");
      check(rsp_rdata, 1'b0, "R1");

      // R3 pass-through
      wr(4'd5, 1); rd(4'd5, "R3");
      wr(4'd5, 0); rd(4'd5, "R3");
      // R2: data held while idle
      wr(4'd6, 1); rd(4'd6, "R2");
      @(negedge clk); check(rsp_rdata, 1'b1, "R2");
      wr(4'd6, 0); check(rsp_rdata, 1'b1, "R2");

      // R4 stuck-at-1 visible straight after reset
      configure(3'd1, 4'd2, 4'd9, 1, 0, 0);
      rd(4'd2, "R4"); check(rsp_rdata, 1'b1, "R4");
      wr(4'd2, 0); rd(4'd2, "R4");

      // R5 up-transition fault
      configure(3'd2, 4'd4, 4'd0, 0, 0, 0);
      wr(4'd4, 1); rd(4'd4, "R5"); check(rsp_rdata, 1'b0, "R5");
      // R6 down-transition fault
      configure(3'd2, 4'd4, 4'd0, 1, 0, 0);
      wr(4'd4, 1); rd(4'd4, "R6"); check(rsp_rdata, 1'b1, "R6");
      wr(4'd4, 0); rd(4'd4, "R6");

      // R7 forcing coupling, rising aggressor forces 1
      configure(3'd3, 4'd7, 4'd8, 0, 1, 1);
      wr(4'd8, 1); rd(4'd7, "R7"); check(rsp_rdata, 1'b1, "R7");
      // R9: repeated same-value write does not fire
      wr(4'd7, 0); wr(4'd8, 1); rd(4'd7, "R9"); check(rsp_rdata, 1'b0, "R9");
      // R9: falling transition away from trigger does not fire
      wr(4'd8, 0); rd(4'd7, "R9");

      // R8 inverting coupling on falling aggressor
      configure(3'd4, 4'd1, 4'd12, 0, 0, 0);
      wr(4'd12, 1); wr(4'd12, 0); rd(4'd1, "R8"); check(rsp_rdata, 1'b1, "R8");
      wr(4'd12, 1); wr(4'd12, 0); rd(4'd1, "R8"); check(rsp_rdata, 1'b0, "R8");

      // constrained random phases
      for (int ph = 0; ph < 15; ph++) begin
         logic [AW-1:0] v, g;
         v = AW'($urandom % DEPTH);
         g = AW'($urandom % DEPTH);
         if (g == v) g = v + 1'b1;
         configure(3'(ph % 5), v, g, 1'($urandom), 1'($urandom), 1'($urandom));
         for (int op = 0; op < 150; op++) begin
            logic [AW-1:0] a;
            int sel = $urandom % 4;
            a = (sel == 0) ? v : (sel == 1) ? g : AW'($urandom % DEPTH);
            if ($urandom % 2) wr(a, 1'($urandom));
            else rd(a, tag_for(a));
         end
      end

      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not complete, actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule